// File: doc/BRIEF.md
# Prescaled I2C Master Clock Generator

This block produces the SCL waveform of an I2C master from the system clock. The caller supplies an 8-bit bit-rate value BR and a 2-bit prescaler select PS; the block computes a half-period of H = 8 + BR·4^PS system clocks. It then alternates a low phase, with SCL actively pulled down, and a released phase, each H clocks long, giving a full period of 16 + 2·BR·4^PS clocks. The SCL output is open-drain: the block only ever asserts a pull-down request and never drives the line high.

Two single-cycle strobes tell the surrounding byte engine when to act. One marks the middle of the low phase, where SDA may change. The other marks the middle of the high phase, where SDA is sampled. The block senses the real bus level. While a slave keeps SCL low after the release (clock stretching), the high-phase counter waits, so a hold of k clocks lengthens the period by exactly k. Bit-rate values below 10 are rejected: the block raises an error flag and leaves the line released.

Top module: `scl_rate_gen`

## Requirements
- R1: With the bus following the pull-down, the pull-down request stays asserted for exactly H = 8 + BR·(1, 4, 16, 64 for PS = 0, 1, 2, 3) consecutive cycles in each low phase.
- R2: With no external hold, the request stays deasserted for exactly H cycles between two low phases, so one period is 16 + 2·BR·4^PS cycles.
- R3: The mid-low strobe pulses for exactly one cycle per low phase, in cycle floor(H/2)+1 of that phase (counting from 1).
- R4: The mid-high strobe pulses for exactly one cycle per released phase, in cycle k+floor(H/2)+1, where k is the number of cycles an external hold kept the bus low after the release. It never pulses while the bus reads low.
- R5: An external hold that keeps the bus low for k cycles after the release lengthens the released phase, and the period, by exactly k cycles.
- R6: With the enable low, the pull-down request is deasserted from the next cycle on, no strobes occur and the counters stay at zero. After the enable rises, the request is asserted in the next cycle and a full low phase follows.
- R7: When the enable is high and BR < 10, the error flag is high from the next cycle on. While the flag is high, the line is never pulled down and no strobes occur. With BR ≥ 10, or with the enable low, the flag reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Runs the generator while high |
| bit_rate | input | 8 | Bit-rate value BR |
| presc_sel | input | 2 | Prescaler select PS (scale 4^PS) |
| scl_in | input | 1 | Sensed SCL bus level |
| scl_drive_low | output | 1 | Open-drain pull-down request for SCL |
| mid_low_stb | output | 1 | One-cycle pulse at the middle of SCL low |
| mid_high_stb | output | 1 | One-cycle pulse at the middle of SCL high |
| cfg_err | output | 1 | Enabled with a bit-rate value below the minimum |

## Verification
The pull-down request and the error flag come from registers, so each responds one cycle after the enable or the bit-rate value changes. The strobes are due at fixed cycle positions inside each phase, and the released phase ends exactly k cycles after the bus level rises. The bench changes every input just after the falling clock edge and samples at the next falling edge. It counts phase lengths and strobe positions in whole sampled cycles and compares them with H and k computed from the formula. The external hold is dropped after the (k+1)-th released sample, so exactly k rising edges see the bus low.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;
endpackage

// File: rtl/scl_half_calc.sv
module scl_half_calc #(
   parameter int BR_W      = 8,
   parameter int PS_W      = 2,
   parameter int PS_STEP   = 2,
   parameter int BASE_HALF = 8,
   parameter int CNT_W     = 15
) (
   input  logic [BR_W-1:0]  br,
   input  logic [PS_W-1:0]  ps,
   output logic [CNT_W-1:0] half
);
   localparam int TERMS   = 2 ** PS_W;
   localparam int NEED_W  = BR_W + PS_STEP * (TERMS - 1) + 1;

   if (CNT_W < NEED_W) begin : g_bad_width
      $error("scl_half_calc: CNT_W too small for largest half period");
   end
   if (BASE_HALF < 1) begin : g_bad_base
      $error("scl_half_calc: BASE_HALF must be positive");
   end

   logic [CNT_W-1:0] terms [TERMS];

   // one scaled copy of the bit-rate value per prescaler setting
   for (genvar i = 0; i < TERMS; i++) begin : g_term
      assign terms[i] = CNT_W'(br) << (PS_STEP * i);
   end

   assign half = CNT_W'(BASE_HALF) + terms[ps];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_gen_pkg::*;
#(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half,
   input  logic             scl_s,
   output logic             drive_low,
   output logic             mid_low,
   output logic             mid_high
);
   scl_phase_e       ph;
   logic [CNT_W-1:0] cnt;
   logic             last;
   logic [CNT_W-1:0] mid_pt;

   // >= keeps the phase bounded if the half length shrinks mid-phase
   assign last   = (cnt >= half - CNT_W'(1));
   assign mid_pt = half >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (!run) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               ph  <= PH_LOW;
               cnt <= '0;
            end
            PH_LOW: begin
               if (last) begin
                  ph  <= PH_HIGH;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_HIGH: begin
               // counting waits while a slave still holds the line low
               if (scl_s) begin
                  if (last) begin
                     ph  <= PH_LOW;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            default: begin
               ph  <= PH_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end

   assign drive_low = (ph == PH_LOW);
   assign mid_low   = (ph == PH_LOW) && (cnt == mid_pt);
   assign mid_high  = (ph == PH_HIGH) && scl_s && (cnt == mid_pt);

   // R6: disabling returns to idle with a cleared counter
   a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (ph == PH_IDLE && cnt == '0));

   // R5: a held-low bus freezes the high-phase count
   a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ph == PH_HIGH && !scl_s) |=> (ph == PH_HIGH && cnt == $past(cnt)));

   // R2: the end of a low phase hands over to a fresh high phase
   a_r2_low_to_high: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ph == PH_LOW && last) |=> (ph == PH_HIGH && cnt == '0));

   // R4: the mid-high strobe only appears with the bus reading high
   a_r4_high_strobe_bus: assert property (@(posedge clk) disable iff (!rst_n)
      mid_high |-> scl_s);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
   parameter int BR_W        = 8,
   parameter int PS_W        = 2,
   parameter int PS_STEP     = 2,
   parameter int BASE_HALF   = 8,
   parameter int MIN_BR      = 10,
   parameter int SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [BR_W-1:0] bit_rate,
   input  logic [PS_W-1:0] presc_sel,
   input  logic            scl_in,
   output logic            scl_drive_low,
   output logic            mid_low_stb,
   output logic            mid_high_stb,
   output logic            cfg_err
);
   localparam int CNT_W = BR_W + PS_STEP * (2 ** PS_W - 1) + 1;

   if (MIN_BR >= 2 ** BR_W) begin : g_bad_min
      $error("scl_rate_gen: MIN_BR exceeds the bit-rate range");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("scl_rate_gen: SYNC_STAGES must not be negative");
   end

   logic             br_ok;
   logic             run;
   logic             scl_s;
   logic [CNT_W-1:0] half;

   assign br_ok = (bit_rate >= BR_W'(MIN_BR));
   assign run   = en && br_ok;

   // optional resynchronisation of the sensed bus level
   if (SYNC_STAGES == 0) begin : g_sync_none
      assign scl_s = scl_in;
   end else begin : g_sync_ff
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[SYNC_STAGES-2+1-1:0], scl_in} >> 0;
      end
      assign scl_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= en && !br_ok;
   end

   scl_half_calc #(
      .BR_W      (BR_W),
      .PS_W      (PS_W),
      .PS_STEP   (PS_STEP),
      .BASE_HALF (BASE_HALF),
      .CNT_W     (CNT_W)
   ) u_half (
      .br   (bit_rate),
      .ps   (presc_sel),
      .half (half)
   );

   scl_phase_fsm #(
      .CNT_W (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .half      (half),
      .scl_s     (scl_s),
      .drive_low (scl_drive_low),
      .mid_low   (mid_low_stb),
      .mid_high  (mid_high_stb)
   );

   // R7: flag follows an enabled, too-small bit-rate value
   a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (en && bit_rate < BR_W'(MIN_BR)) |=> cfg_err);

   // R7: nothing toggles while the configuration is rejected
   a_r7_quiet_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!scl_drive_low && !mid_low_stb && !mid_high_stb));

   // R6: the line is released one cycle after the enable drops
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !scl_drive_low);
endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] bit_rate = 8'd10;
   logic [1:0] presc_sel = 2'd0;
   logic       hold = 1'b0;
   logic       scl_in;
   logic       scl_drive_low, mid_low_stb, mid_high_stb, cfg_err;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // wired-AND bus: master pull-down or external slave hold
   assign scl_in = !(scl_drive_low || hold);

   scl_rate_gen u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .bit_rate      (bit_rate),
      .presc_sel     (presc_sel),
      .scl_in        (scl_in),
      .scl_drive_low (scl_drive_low),
      .mid_low_stb   (mid_low_stb),
      .mid_high_stb  (mid_high_stb),
      .cfg_err       (cfg_err)
   );

   function automatic int exp_half(int br, int ps);
      int scale = 1;
      for (int i = 0; i < ps; i++) scale = scale * 4;
      return 8 + br * scale;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // measure one low and one released phase; k = external hold length
   task automatic measure(int br, int ps, int k);
      int h, lowcnt, relcnt, ml_n, ml_at, mh_n, mh_at;
      @(negedge clk);
      en = 1'b0;
      hold = 1'b0;
      repeat (2) @(negedge clk);
      bit_rate = 8'(br);
      presc_sel = 2'(ps);
      en = 1'b1;
      h = exp_half(br, ps);
      lowcnt = 0; relcnt = 0; ml_n = 0; ml_at = 0; mh_n = 0; mh_at = 0;
      @(negedge clk);
      chk(scl_drive_low == 1'b1, "R6 start", int'(scl_drive_low), 1);
      while (scl_drive_low) begin
         lowcnt++;
         if (mid_low_stb) begin ml_n++; ml_at = lowcnt; end
         if (lowcnt == 1 && k > 0) hold = 1'b1;
         @(negedge clk);
      end
      while (!scl_drive_low) begin
         relcnt++;
         if (mid_high_stb) begin
            mh_n++; mh_at = relcnt;
            if (!scl_in) chk(1'b0, "R4 strobe while bus low", 0, 1);
         end
         if (relcnt == k + 1) hold = 1'b0;
         @(negedge clk);
      end
      chk(lowcnt == h, "R1 low length", lowcnt, h);
      chk(relcnt == h + k, (k > 0) ? "R5 stretched high" : "R2 high length",
          relcnt, h + k);
      chk(lowcnt + relcnt == 16 + 2 * (h - 8) + k, "R2 period",
          lowcnt + relcnt, 16 + 2 * (h - 8) + k);
      chk(ml_n == 1 && ml_at == h / 2 + 1, "R3 mid-low position", ml_at, h / 2 + 1);
      chk(mh_n == 1 && mh_at == k + h / 2 + 1, "R4 mid-high position",
          mh_at, k + h / 2 + 1);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int seed_v;
      seed_v = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(!scl_drive_low && !mid_low_stb && !mid_high_stb && !cfg_err,
          "R6 reset idle", int'(scl_drive_low), 0);

      // directed corners
      measure(10, 0, 0);
      measure(255, 3, 0);
      measure(11, 1, 0);
      measure(12, 1, 5);
      measure(10, 0, 1);

      // random pairs with random holds
      for (int n = 0; n < 6; n++) begin
         int br, ps, k;
         br = 10 + int'($urandom_range(245, 0));
         ps = int'($urandom_range(2, 0));
         k  = (n % 2 == 0) ? 0 : int'($urandom_range(40, 1));
         measure(br, ps, k);
      end

      // R6: disable in mid-low phase releases next cycle, stays quiet
      @(negedge clk);
      en = 1'b0;
      bit_rate = 8'd20; presc_sel = 2'd0;
      @(negedge clk);
      en = 1'b1;
      repeat (5) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(!scl_drive_low, "R6 release after disable", int'(scl_drive_low), 0);
      begin
         int act = 0;
         for (int i = 0; i < 60; i++) begin
            if (scl_drive_low || mid_low_stb || mid_high_stb) act++;
            @(negedge clk);
         end
         chk(act == 0, "R6 quiet while disabled", act, 0);
      end
      en = 1'b1;
      @(negedge clk);
      chk(scl_drive_low, "R6 restart low", int'(scl_drive_low), 1);

      // R7: too-small bit-rate value
      en = 1'b0;
      repeat (2) @(negedge clk);
      bit_rate = 8'd9;
      en = 1'b1;
      @(negedge clk);
      chk(cfg_err, "R7 flag raised", int'(cfg_err), 1);
      begin
         int act = 0;
         for (int i = 0; i < 50; i++) begin
            if (scl_drive_low || mid_low_stb || mid_high_stb || !cfg_err) act++;
            @(negedge clk);
         end
         chk(act == 0, "R7 line idle under error", act, 0);
      end
      en = 1'b0;
      bit_rate = 8'd5;
      @(negedge clk);
      chk(!cfg_err, "R7 flag low when disabled", int'(cfg_err), 0);
      bit_rate = 8'd10;
      en = 1'b1;
      @(negedge clk);
      chk(!cfg_err && scl_drive_low, "R7 minimum value accepted",
          int'(cfg_err), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule